// File: doc/BRIEF.md
# I2C Slave Address-Phase Detector

This block is the front end of an I2C slave that listens to the first byte after a START or repeated START. It takes SCL and SDA that are already synchronised to the system clock, along with one-cycle START and STOP detect pulses. On each rising edge of SCL it shifts SDA in, most significant bit first. When the eighth bit is complete, it compares the byte against a locally held slave address and checks it for extension codes.

A byte is an extension code when its upper nibble is all zeros or all ones. This covers the general call (address 0000000 with a write bit) and the 10-bit address headers (11110xx followed by the R/W bit). In either case the block sets a held extension flag. A byte whose seven address bits equal the local address sets a held coincidence flag. Either result raises a single-cycle interrupt pulse at the falling SCL edge that ends the eighth bit, and marks the slave as taking part in the transfer.

Software can write the local address through a write strobe. Software can also pulse a release input, which withdraws the slave from the transfer and makes it ignore the bus until the next START. The interrupt and flags let software decide what to do after an extension code.

Top module: `i2c_addr_detect`

## Requirements
- R1: After reset `ext_flag`, `coin_flag`, `part_o`, `rw_flag` and `irq` are 0, `own_addr` equals the parameter RESET_ADDR, and the slave is in standby: clocks before the first START produce no interrupt.
- R2: After a START, SDA is sampled on each of the next eight SCL rising edges, and the first bit sampled is bit 7 of the received byte. `irq` is high for exactly one system clock, in the cycle after the eighth SCL falling edge is seen, and only when the byte is an extension code or an address match. Further SCL clocks raise no more interrupts until the next START.
- R3: `ext_flag` is set when received bits 7:4 are 0000 or 1111.
- R4: `coin_flag` is set when received bits 7:1 equal `own_addr`. `rw_flag` takes received bit 0.
- R5: The byte 0x00 (general call) sets `ext_flag` and raises `irq`.
- R6: When `own_addr` is 11110xx, a received 11110xx0 sets both `ext_flag` and `coin_flag`. A received 11110xx1 (read header) also sets both, with `rw_flag` at 1.
- R7: `own_addr` changes only on `addr_we`. Receiving any byte, including an extension code, leaves it unchanged.
- R8: `part_o` is set when a byte sets either flag. A `release_i` pulse clears `part_o` and puts the slave in standby: later bytes before the next START give no interrupt and leave the flags unchanged.
- R9: A STOP pulse clears `ext_flag`, `coin_flag` and `part_o`.
- R10: A START clears both flags, restarts the bit count and ends standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Synchronised serial clock |
| sda | input | 1 | Synchronised serial data |
| start_det | input | 1 | One-cycle pulse on START or repeated START |
| stop_det | input | 1 | One-cycle pulse on STOP |
| addr_we | input | 1 | Write strobe for the local address |
| addr_wdata | input | 7 | New local address |
| release_i | input | 1 | Software release pulse |
| own_addr | output | 7 | Current local address |
| ext_flag | output | 1 | Extension code received |
| coin_flag | output | 1 | Address coincidence |
| rw_flag | output | 1 | R/W bit of the last evaluated byte |
| part_o | output | 1 | Slave is taking part in the transfer |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach is the one where both flags are set by a single byte. It needs the local address programmed into the 10-bit header range and a matching header sent in both directions. The bench reaches it by sweeping all 256 byte values against several programmed addresses, including 11110xx patterns, and computing each expected flag from the nibble and address rules. The release path is also hard to reach, because it needs a participating slave, then a release, then a byte that would otherwise match. The bench builds that sequence explicitly and then confirms that a new START brings the slave back.

// File: rtl/i2c_addr_pkg.sv
// Shared widths and result type for the I2C address-phase detector.
package i2c_addr_pkg;
    localparam int BYTE_W = 8;              // bits in one address byte
    localparam int ADDR_W = BYTE_W - 1;     // address bits, R/W excluded
    localparam int NIB_W  = 4;              // width of the extension nibble

    typedef struct packed {
        logic ext;
        logic coin;
    } addr_hit_t;
endpackage

// File: rtl/scl_edge_det.sv
// Detects SCL rising and falling edges by comparing the current input
// with a registered copy. Assumes scl is already synchronised to clk.
// The registered copy resets high, which is the idle bus level.
module scl_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;

    // hold last sample of SCL
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl;
    end

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/addr_shifter.sv
// Collects BYTE_W bits MSB first on SCL rising edges. A restart pulse
// empties the register and the count. It stops shifting once full,
// so later clocks of the same transfer leave the byte intact.
module addr_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              enable,
    input  logic              shift,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_o,
    output logic              full
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;

    // shift SDA in and count bits until the byte is complete
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
            sr  <= '0;
        end else if (enable && shift && cnt != FULL_CNT) begin
            sr  <= {sr[BYTE_W-2:0], bit_in};
            cnt <= cnt + 1'b1;
        end
    end

    assign byte_o = sr;
    assign full   = (cnt == FULL_CNT);

    // R2: the bit count never runs past one byte
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
endmodule

// File: rtl/addr_classifier.sv
// Pure combinational decode of the received address bits: extension
// code (upper nibble all zeros or all ones) and local coincidence.
module addr_classifier
    import i2c_addr_pkg::*;
#(
    parameter int AW = 7,
    parameter int NW = 4
) (
    input  logic [AW-1:0] rx_addr,
    input  logic [AW-1:0] local_addr,
    output addr_hit_t     hit
);
    logic [NW-1:0] nib;

    // decode the extension nibble and the full address compare
    always_comb begin
        nib      = rx_addr[AW-1 -: NW];
        hit.ext  = (nib == '0) || (nib == '1);
        hit.coin = (rx_addr == local_addr);
    end
endmodule

// File: rtl/i2c_addr_detect.sv
// Address-phase detector of an I2C slave. Holds the local address,
// assembles the first byte after START, and on the eighth SCL falling
// edge latches extension and coincidence flags and pulses irq once.
// Assumes scl/sda are synchronised and start/stop are one-cycle pulses.
// Priority on a shared cycle: START, then STOP, then release.
module i2c_addr_detect
    import i2c_addr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_ADDR = 7'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              release_i,
    output logic [ADDR_W-1:0] own_addr,
    output logic              ext_flag,
    output logic              coin_flag,
    output logic              rw_flag,
    output logic              part_o,
    output logic              irq
);
    logic              scl_rise, scl_fall;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_full;
    logic              standby, done;
    addr_hit_t         hit;

    scl_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    addr_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_det),
        .enable  (~standby),
        .shift   (scl_rise),
        .bit_in  (sda),
        .byte_o  (rx_byte),
        .full    (rx_full)
    );

    addr_classifier #(.AW(ADDR_W), .NW(NIB_W)) u_cls (
        .rx_addr    (rx_byte[BYTE_W-1:1]),
        .local_addr (own_addr),
        .hit        (hit)
    );

    // local address register, written by software only
    always_ff @(posedge clk) begin
        if (!rst_n)       own_addr <= RESET_ADDR;
        else if (addr_we) own_addr <= addr_wdata;
    end

    // flags, participation, standby and the interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_flag  <= 1'b0;
            coin_flag <= 1'b0;
            rw_flag   <= 1'b0;
            part_o    <= 1'b0;
            standby   <= 1'b1;
            done      <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start_det) begin
                ext_flag  <= 1'b0;
                coin_flag <= 1'b0;
                part_o    <= 1'b0;
                standby   <= 1'b0;
                done      <= 1'b0;
            end else if (stop_det) begin
                ext_flag  <= 1'b0;
                coin_flag <= 1'b0;
                part_o    <= 1'b0;
                standby   <= 1'b1;
            end else if (release_i) begin
                part_o    <= 1'b0;
                standby   <= 1'b1;
            end else if (!standby && !done && rx_full && scl_fall) begin
                done      <= 1'b1;
                ext_flag  <= hit.ext;
                coin_flag <= hit.coin;
                rw_flag   <= rx_byte[0];
                part_o    <= hit.ext | hit.coin;
                irq       <= hit.ext | hit.coin;
            end
        end
    end

    // R2
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ext_flag || coin_flag));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_we |=> $stable(own_addr));

    // R8
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !part_o);

    // R9
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!ext_flag && !coin_flag && !part_o));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!ext_flag && !coin_flag && !irq));
endmodule

// File: tb/sim_i2c_addr_detect.sv
module sim_i2c_addr_detect;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] RST_ADDR = 7'h7F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       start_det = 1'b0, stop_det = 1'b0;
    logic       addr_we = 1'b0, release_i = 1'b0;
    logic [6:0] addr_wdata = '0;
    logic [6:0] own_addr;
    logic       ext_flag, coin_flag, rw_flag, part_o, irq;

    int errors = 0;
    int checks = 0;
    int irq_seen = 0;

    i2c_addr_detect #(.RESET_ADDR(RST_ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
        .start_det(start_det), .stop_det(stop_det),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .release_i(release_i),
        .own_addr(own_addr), .ext_flag(ext_flag), .coin_flag(coin_flag),
        .rw_flag(rw_flag), .part_o(part_o), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (irq) irq_seen++;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_det = 1'b1; tick(1); start_det = 1'b0; tick(1);
    endtask

    task automatic pulse_stop();
        stop_det = 1'b1; tick(1); stop_det = 1'b0; tick(1);
    endtask

    task automatic write_addr(input logic [6:0] a);
        addr_wdata = a; addr_we = 1'b1; tick(1); addr_we = 1'b0; tick(1);
    endtask

    // clocks one byte onto the bus; returns irq pulses seen at the 8th fall
    task automatic send_byte(input logic [7:0] b, output int pulses, output int irq_now);
        int start_cnt;
        start_cnt = irq_seen;
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; sda = b[i]; tick(2);
            scl = 1'b1; tick(2);
        end
        scl = 1'b0; tick(1);
        irq_now = int'(irq);
        tick(1);
        // ninth (acknowledge) clock must not raise a second interrupt
        scl = 1'b1; tick(2); scl = 1'b0; tick(2); scl = 1'b1; tick(1);
        pulses = irq_seen - start_cnt;
    endtask

    initial begin
        int pulses, irq_now;
        logic [6:0] owns[4];
        logic [3:0] nib;
        logic exp_ext, exp_coin;
        owns[0] = 7'h50; owns[1] = 7'h78; owns[2] = 7'h7B; owns[3] = 7'h00;

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset values
        check("R1 ext", ext_flag, 0);
        check("R1 coin", coin_flag, 0);
        check("R1 part", part_o, 0);
        check("R1 irq", irq, 0);
        check("R1 rw", rw_flag, 0);
        check("R1 own_addr", own_addr, RST_ADDR);
        // R1 / R10: standby before first START, general call ignored
        send_byte(8'h00, pulses, irq_now);
        check("R1 no irq before START", pulses, 0);
        check("R1 no ext before START", ext_flag, 0);

        // R2-R7, R9: sweep every byte against several local addresses
        foreach (owns[k]) begin
            write_addr(owns[k]);
            check("R7 write", own_addr, owns[k]);
            for (int b = 0; b < 256; b++) begin
                nib = b[7:4];
                exp_ext  = (nib == 4'h0) || (nib == 4'hF);
                exp_coin = (b[7:1] == owns[k]);
                pulse_start();
                check("R10 flags cleared", {ext_flag, coin_flag}, 0);
                send_byte(8'(b), pulses, irq_now);
                check("R2 irq at 8th fall", irq_now, int'(exp_ext | exp_coin));
                check("R2 single pulse", pulses, int'(exp_ext | exp_coin));
                check("R3 ext", ext_flag, exp_ext);
                check("R4 coin", coin_flag, exp_coin);
                if (exp_ext | exp_coin) check("R4 rw", rw_flag, b & 1);
                check("R8 part", part_o, int'(exp_ext | exp_coin));
                check("R7 own unchanged", own_addr, owns[k]);
                if (b == 0) check("R5 general call", {ext_flag, irq_now[0]}, 2'b11);
                if (owns[k][6:2] == 5'b11110 && b[7:1] == owns[k])
                    check("R6 10-bit header", {ext_flag, coin_flag, rw_flag}, {2'b11, b[0]});
                pulse_stop();
                check("R9 stop clears", {ext_flag, coin_flag, part_o}, 0);
            end
        end

        // R8: release after an extension code, then bus ignored until START
        write_addr(7'h50);
        pulse_start();
        send_byte(8'h00, pulses, irq_now);
        check("R8 part before release", part_o, 1);
        release_i = 1'b1; tick(1); release_i = 1'b0; tick(1);
        check("R8 part after release", part_o, 0);
        check("R8 ext held", ext_flag, 1);
        send_byte(8'hA0, pulses, irq_now);
        check("R8 no irq in standby", pulses, 0);
        check("R8 coin unchanged", coin_flag, 0);
        check("R8 ext unchanged", ext_flag, 1);
        // R10: START leaves standby
        pulse_start();
        send_byte(8'hA0, pulses, irq_now);
        check("R10 irq after START", pulses, 1);
        check("R10 coin after START", coin_flag, 1);
        check("R10 ext after START", ext_flag, 0);
        // R10: repeated START restarts count mid-byte
        pulse_start();
        scl = 1'b0; sda = 1'b1; tick(2); scl = 1'b1; tick(2);
        pulse_start();
        send_byte(8'hA1, pulses, irq_now);
        check("R10 repeated START realigns", {coin_flag, rw_flag}, 2'b11);
        pulse_stop();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule